// File: doc/BRIEF.md
# Condition-Register Ternary Logic Unit

This unit keeps a 32-bit condition register split into eight 4-bit fields. Each operation names one target field and two source fields. At every bit position of a field, the unit reads the target bit and the two source bits and uses them as a 3-bit index into an 8-entry truth table given as an immediate. Under control of a 4-bit write mask, the looked-up bits replace the target field's bits. Because the target field is also a table input, an operation can compute any three-input Boolean function of three fields, including functions in which the field's own previous contents take part.

An operation is accepted on the cycle in which `op_valid` is high. The register shows the new value after the next clock edge. `op_done` is high for exactly that cycle. A new operation can be accepted every cycle. A whole-register load port overwrites all 32 bits and takes precedence over an operation presented in the same cycle. The full register can always be read on `cr_out`.

A two-state controller produces the done strobe. Its states are `CTL_IDLE` (no result retired this cycle) and `CTL_DONE` (a result was written at the last edge). Its transitions are:
- `accept`: IDLE to DONE, or DONE to DONE, on an operation without a load.
- `rest`: IDLE to IDLE when no operation is accepted.
- `retire`: DONE to IDLE when no new operation is accepted.

Reset forces `CTL_IDLE`.

Top module: `crt_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `cr_out` to all zeros and holds `op_done` low in the following cycle.
- R2: Field n (n = 0..7) occupies `cr_out[31-4n : 28-4n]`, so field 0 is the top nibble. Within a field, bit position j of the 4-bit vectors (`op_mask[j]`, field[j]) is the same physical bit, with j = 3 as the field's most significant bit.
- R3: For each bit position j of the target field, the table index is {target[j], sourceA[j], sourceB[j]}, with the target bit as the index MSB. The result bit is `op_lut[index]`, where `op_lut[0]` is the least significant immediate bit.
- R4: Target bit j takes the result bit only when `op_mask[j]` is 1; otherwise it keeps its previous value.
- R5: An operation changes no field other than the target field.
- R6: All three fields are read from the register value that existed before the operation. This holds when `op_tgt` equals `op_srca`, `op_srcb` or both.
- R7: An operation accepted in cycle c is visible on `cr_out` in cycle c+1, and `op_done` is high in cycle c+1. Operations may be issued in consecutive cycles.
- R8: When `ld_valid` is high, `cr_out` equals `ld_data` in the next cycle. If `op_valid` is also high in that cycle, the operation is dropped and no `op_done` follows.
- R9: In a cycle with neither an operation nor a load, `cr_out` keeps its value, and `op_done` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| op_tgt | input | 3 | Target field select (also third table input) |
| op_srca | input | 3 | First source field select |
| op_srcb | input | 3 | Second source field select |
| op_lut | input | 8 | Truth-table immediate, indexed LSB-first |
| op_mask | input | 4 | Per-bit write mask for the target field |
| ld_valid | input | 1 | Whole-register load strobe |
| ld_data | input | 32 | Whole-register load value |
| cr_out | output | 32 | Current condition register contents |
| op_done | output | 1 | High in the cycle an operation's result appears |

## Verification
The bench targets selector aliasing: the target equal to one source, the target equal to both sources, and the two sources equal to each other. A design that wrote results before reading the sources, or that read the target after a partial update, would give values that differ from the pre-operation model. Partial masks and the mask-zero case expose a design that writes unmasked bits or reverses the bit order inside the nibble. A simultaneous load and operation catches a design that lets the operation win or still pulses done. Back-to-back random operations catch a result or done strobe that arrives a cycle late or is lost when the next issue follows immediately.

// File: rtl/crt_pkg.sv
package crt_pkg;

    // done-strobe controller states
    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_DONE = 1'b1
    } ctl_state_e;

    // a ternary table always has three inputs
    localparam int TERN_IN  = 3;
    localparam int TABLE_SZ = 1 << TERN_IN;

endpackage

// File: rtl/crt_field_read.sv
module crt_field_read #(
    parameter  int NF = 8,
    parameter  int FW = 4,
    localparam int SW = $clog2(NF),
    localparam int RW = NF * FW
) (
    input  logic [RW-1:0] reg_i,
    input  logic [SW-1:0] sel_i,
    output logic [FW-1:0] field_o
);

    logic [FW-1:0] slices [NF];

    // field 0 sits at the top of the register
    for (genvar n = 0; n < NF; n++) begin : g_slice
        assign slices[n] = reg_i[RW-1-FW*n -: FW];
    end

    assign field_o = slices[sel_i];

endmodule

// File: rtl/crt_lut_eval.sv
module crt_lut_eval
    import crt_pkg::*;
#(
    parameter int FW = 4
) (
    input  logic [FW-1:0]       tgt_i,
    input  logic [FW-1:0]       a_i,
    input  logic [FW-1:0]       b_i,
    input  logic [TABLE_SZ-1:0] lut_i,
    input  logic [FW-1:0]       mask_i,
    output logic [FW-1:0]       merged_o
);

    for (genvar j = 0; j < FW; j++) begin : g_bit
        logic [TERN_IN-1:0] idx;
        assign idx = {tgt_i[j], a_i[j], b_i[j]};
        // a masked-off position keeps the old target bit
        assign merged_o[j] = mask_i[j] ? lut_i[idx] : tgt_i[j];
    end

endmodule

// File: rtl/crt_reg_store.sv
module crt_reg_store #(
    parameter  int NF = 8,
    parameter  int FW = 4,
    localparam int SW = $clog2(NF),
    localparam int RW = NF * FW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [RW-1:0] load_data_i,
    input  logic          wr_i,
    input  logic [SW-1:0] wr_sel_i,
    input  logic [FW-1:0] wr_field_i,
    output logic [RW-1:0] reg_o
);

    logic [RW-1:0] reg_q;
    logic [RW-1:0] merged;

    for (genvar n = 0; n < NF; n++) begin : g_ins
        assign merged[RW-1-FW*n -: FW] =
            (wr_sel_i == SW'(n)) ? wr_field_i : reg_q[RW-1-FW*n -: FW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else if (load_i) begin
            reg_q <= load_data_i;
        end else if (wr_i) begin
            reg_q <= merged;
        end
    end

    assign reg_o = reg_q;

endmodule

// File: rtl/crt_ctrl.sv
module crt_ctrl
    import crt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic op_valid_i,
    input  logic load_i,
    output logic write_o,
    output logic done_o
);

    ctl_state_e state_q;
    ctl_state_e state_d;
    logic       accept;

    // a load in the same cycle cancels the operation
    assign accept = op_valid_i && !load_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CTL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_IDLE: state_d = accept ? CTL_DONE : CTL_IDLE;
            CTL_DONE: state_d = accept ? CTL_DONE : CTL_IDLE;
            default:  state_d = CTL_IDLE;
        endcase
    end

    always_comb begin
        write_o = accept;
        done_o  = (state_q == CTL_DONE);
    end

endmodule

// File: rtl/crt_unit.sv
module crt_unit
    import crt_pkg::*;
#(
    parameter  int NUM_FIELDS = 8,
    parameter  int FIELD_W    = 4,
    localparam int SEL_W      = $clog2(NUM_FIELDS),
    localparam int REG_W      = NUM_FIELDS * FIELD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [SEL_W-1:0]    op_tgt,
    input  logic [SEL_W-1:0]    op_srca,
    input  logic [SEL_W-1:0]    op_srcb,
    input  logic [TABLE_SZ-1:0] op_lut,
    input  logic [FIELD_W-1:0]  op_mask,
    input  logic                ld_valid,
    input  logic [REG_W-1:0]    ld_data,
    output logic [REG_W-1:0]    cr_out,
    output logic                op_done
);

    logic [FIELD_W-1:0] f_tgt;
    logic [FIELD_W-1:0] f_a;
    logic [FIELD_W-1:0] f_b;
    logic [FIELD_W-1:0] f_new;
    logic               wr_en;

    // all three reads come from the current register, before any write
    crt_field_read #(.NF(NUM_FIELDS), .FW(FIELD_W)) u_rd_tgt (
        .reg_i(cr_out), .sel_i(op_tgt), .field_o(f_tgt));
    crt_field_read #(.NF(NUM_FIELDS), .FW(FIELD_W)) u_rd_a (
        .reg_i(cr_out), .sel_i(op_srca), .field_o(f_a));
    crt_field_read #(.NF(NUM_FIELDS), .FW(FIELD_W)) u_rd_b (
        .reg_i(cr_out), .sel_i(op_srcb), .field_o(f_b));

    crt_lut_eval #(.FW(FIELD_W)) u_eval (
        .tgt_i   (f_tgt),
        .a_i     (f_a),
        .b_i     (f_b),
        .lut_i   (op_lut),
        .mask_i  (op_mask),
        .merged_o(f_new)
    );

    crt_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .op_valid_i(op_valid),
        .load_i    (ld_valid),
        .write_o   (wr_en),
        .done_o    (op_done)
    );

    crt_reg_store #(.NF(NUM_FIELDS), .FW(FIELD_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ld_valid),
        .load_data_i(ld_data),
        .wr_i       (wr_en),
        .wr_sel_i   (op_tgt),
        .wr_field_i (f_new),
        .reg_o      (cr_out)
    );

endmodule

// File: rtl/crt_unit_chk.sv
module crt_unit_chk #(
    parameter  int NUM_FIELDS = 8,
    parameter  int FIELD_W    = 4,
    localparam int SEL_W      = $clog2(NUM_FIELDS),
    localparam int REG_W      = NUM_FIELDS * FIELD_W
) (
    input logic               clk,
    input logic               rst,
    input logic               op_valid,
    input logic [SEL_W-1:0]   op_tgt,
    input logic [FIELD_W-1:0] op_mask,
    input logic               ld_valid,
    input logic [REG_W-1:0]   ld_data,
    input logic [REG_W-1:0]   cr_out,
    input logic               op_done
);

    function automatic logic [REG_W-1:0] field_span(input logic [SEL_W-1:0] n);
        logic [REG_W-1:0] ones;
        ones = {{(REG_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}};
        return ones << (REG_W - FIELD_W * (int'(n) + 1));
    endfunction

    function automatic logic [REG_W-1:0] mask_span(input logic [SEL_W-1:0] n,
                                                   input logic [FIELD_W-1:0] m);
        logic [REG_W-1:0] wide;
        wide = {{(REG_W-FIELD_W){1'b0}}, m};
        return wide << (REG_W - FIELD_W * (int'(n) + 1));
    endfunction

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cr_out == '0 && !op_done));

    // R8
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> (cr_out == $past(ld_data) && !op_done));

    // R7
    done_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !ld_valid) |=> op_done);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !ld_valid) |=> ($stable(cr_out) && !op_done));

    // R5
    other_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !ld_valid) |=>
        (((cr_out ^ $past(cr_out)) & ~field_span($past(op_tgt))) == '0));

    // R4
    masked_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !ld_valid) |=>
        (((cr_out ^ $past(cr_out)) & ~mask_span($past(op_tgt), $past(op_mask))) == '0));

endmodule

bind crt_unit crt_unit_chk #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_valid(op_valid),
    .op_tgt  (op_tgt),
    .op_mask (op_mask),
    .ld_valid(ld_valid),
    .ld_data (ld_data),
    .cr_out  (cr_out),
    .op_done (op_done)
);

// File: tb/crt_unit_test.sv
module crt_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_tgt = '0;
    logic [2:0]  op_srca = '0;
    logic [2:0]  op_srcb = '0;
    logic [7:0]  op_lut = '0;
    logic [3:0]  op_mask = '0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_data = '0;
    logic [31:0] cr_out;
    logic        op_done;

    int tests  = 0;
    int errors = 0;
    int cyc    = 0;
    logic [31:0] shadow = '0;

    typedef struct {
        int          due;
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    crt_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_tgt(op_tgt),
        .op_srca(op_srca), .op_srcb(op_srcb), .op_lut(op_lut),
        .op_mask(op_mask), .ld_valid(ld_valid), .ld_data(ld_data),
        .cr_out(cr_out), .op_done(op_done)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // field bit i counted MSB-first, register bit 0 = MSB
    function automatic logic fbit(input logic [31:0] r, input int n, input int i);
        return r[31 - (4*n + i)];
    endfunction

    // immediate bit k counted MSB-first
    function automatic logic imm_msb(input logic [7:0] v, input int k);
        return v[7 - k];
    endfunction

    function automatic logic [31:0] model(input logic [31:0] r, input int t,
                                          input int a, input int b,
                                          input logic [7:0] imm, input logic [3:0] m);
        logic [31:0] nr;
        nr = r;
        for (int i = 0; i < 4; i++) begin
            int idx;
            idx = 4*fbit(r, t, i) + 2*fbit(r, a, i) + fbit(r, b, i);
            if (m[3 - i])
                nr[31 - (4*t + i)] = imm_msb(imm, 7 - idx);
        end
        return nr;
    endfunction

    task automatic do_op(input int t, input int a, input int b,
                         input logic [7:0] imm, input logic [3:0] m, input string tag);
        exp_t e;
        @(negedge clk);
        op_valid = 1'b1; ld_valid = 1'b0;
        op_tgt = 3'(t); op_srca = 3'(a); op_srcb = 3'(b);
        op_lut = imm; op_mask = m;
        shadow = model(shadow, t, a, b, imm, m);
        e.due = cyc + 1; e.val = shadow; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic do_load(input logic [31:0] d, input logic with_op);
        @(negedge clk);
        ld_valid = 1'b1; ld_data = d;
        op_valid = with_op;
        op_tgt = 3'd1; op_srca = 3'd2; op_srcb = 3'd3;
        op_lut = 8'hFF; op_mask = 4'hF;
        shadow = d;
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid = 1'b0; ld_valid = 1'b0;
    endtask

    // monitor: retire expected results in their due cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                check(op_done, {e.tag, " R7 done"}, 32'(op_done), 32'd1);
                check(cr_out == e.val, e.tag, cr_out, e.val);
            end else if (op_done) begin
                check(1'b0, "R8/R9 unexpected done", 32'd1, 32'd0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'(cyc), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cr_out == 32'h0, "R1 reset value", cr_out, 32'h0);
        check(!op_done, "R1 done after reset", 32'(op_done), 32'd0);

        // R8 / R2: load then find field 2 at bits 23:20
        do_load(32'h1234_5678, 1'b0);
        idle();
        check(cr_out == 32'h1234_5678, "R8 load", cr_out, 32'h1234_5678);
        do_op(2, 0, 0, 8'hFF, 4'hF, "R2 field 2 set");
        idle();
        check(cr_out == 32'h12F4_5678, "R2 field placement", cr_out, 32'h12F4_5678);

        // R3: majority, xor, select functions
        do_load(32'hA5C3_0F96, 1'b0);
        do_op(0, 1, 2, 8'hE8, 4'hF, "R3 majority");
        do_op(3, 4, 5, 8'h96, 4'hF, "R3 parity");
        do_op(7, 6, 5, 8'hCA, 4'hF, "R3 select");
        do_op(6, 0, 7, 8'h01, 4'hF, "R3 nor3");

        // R4: partial and empty masks
        do_op(1, 2, 3, 8'hFF, 4'b1000, "R4 top bit only");
        do_op(4, 2, 3, 8'h00, 4'b0101, "R4 alt bits");
        do_op(5, 0, 1, 8'h5A, 4'b0000, "R4 mask zero");
        idle();

        // R6: aliasing
        do_load(32'h6C39_E1B4, 1'b0);
        do_op(2, 2, 5, 8'h3C, 4'hF, "R6 tgt=srca");
        do_op(3, 1, 3, 8'h66, 4'hF, "R6 tgt=srcb");
        do_op(4, 4, 4, 8'h0F, 4'hF, "R6 all same invert");
        do_op(5, 6, 6, 8'hA9, 4'b1011, "R6 srca=srcb");
        idle();

        // R8: load wins over a simultaneous op
        do_load(32'hDEAD_BEEF, 1'b1);
        idle();
        check(cr_out == 32'hDEAD_BEEF, "R8 load priority", cr_out, 32'hDEAD_BEEF);

        // R9: idle keeps state and no done
        held = cr_out;
        idle(); idle();
        check(cr_out == held, "R9 idle hold", cr_out, held);
        check(!op_done, "R9 no done", 32'(op_done), 32'd0);

        // R5 / R7: back-to-back random with forced aliasing
        for (int k = 0; k < 400; k++) begin
            int t, a, b;
            if (k % 50 == 0) do_load($urandom, 1'b0);
            t = $urandom_range(0, 7);
            a = ($urandom_range(0, 3) == 0) ? t : $urandom_range(0, 7);
            b = ($urandom_range(0, 3) == 0) ? a : $urandom_range(0, 7);
            do_op(t, a, b, 8'($urandom), 4'($urandom), "R5 R7 random");
            if (k % 7 == 0) idle();
        end
        idle(); idle();
        check(sb.size() == 0, "R7 all retired", 32'(sb.size()), 32'd0);
        check(cr_out == shadow, "R5 final state", cr_out, shadow);

        $display("[TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end

endmodule